// File: doc/BRIEF.md
# Reorder Buffer Commit Controller

This block tracks in-flight instructions of an out-of-order core in program order so that they retire in order. Each dispatched instruction takes one slot in a circular buffer. The slot records the destination logical register, the newly assigned physical register tag, the tag it replaced and the instruction's PC. The block returns the slot index to the dispatcher. Execution units later report completion by that index, optionally flagging an exception or a mispredicted branch. The buffer holds no result values, because results already sit in the physical register file.

The oldest slot retires once it is complete. Its commit event carries the logical register and both physical tags, so the rename logic can update its committed map and free the old tag. A slot flagged with an exception is not retired. When it becomes the oldest, the block raises a trap with its PC and holds until the trap is acknowledged, which empties the buffer. A mispredicted branch squashes every younger slot in the cycle it completes, and the next allocation reuses the slot just after the branch.

Dispatch and commit are valid/ready streams. An allocation transfers when `alloc_valid` and `alloc_ready` are both high. `alloc_ready` drops while the buffer is full, during a flush cycle and while a trap is pending. A commit transfers when `cmt_valid` and `cmt_ready` are both high. While `cmt_ready` is low, `cmt_valid` stays high and the commit payload is held unchanged. Completion, trap and flush pins are plain control signals.

Top module: `rob_commit_ctrl`

## Requirements
- R1: An allocation takes the slot shown on `alloc_idx`. Successive accepted allocations receive consecutive indices that wrap modulo DEPTH, and the first index after reset is 0.
- R2: Once DEPTH slots are occupied, `alloc_ready` is low until a slot is released.
- R3: The oldest slot is offered on the commit stream only after it has completed without an exception. Younger completed slots never commit ahead of it. With `cmt_ready` low, `cmt_valid` and the payload hold.
- R4: Commits leave in allocation order, at most one per cycle. Each commit carries the `lreg`, `pnew` and `pold` values given at allocation.
- R5: A completion with `cmp_exc`=1 makes the slot trap-marked. When that slot is oldest, `exc_valid` is 1 and `exc_pc` is its PC. `cmt_valid` and `alloc_ready` are both 0, and this state holds until acknowledged.
- R6: `exc_ack` high while `exc_valid` is high empties the buffer at that edge. Afterwards `exc_valid` and `cmt_valid` are 0, `alloc_ready` is 1, and `alloc_idx` equals the trapped slot's index.
- R7: A completion with `cmp_mispredict`=1 on a live slot drives `flush_valid`=1 and `flush_idx`=`cmp_idx` in the same cycle, with `alloc_ready` low. Every younger slot is removed, and the next `alloc_idx` is the branch index plus 1 modulo DEPTH.
- R8: A completion naming a slot that is not live is ignored. It raises no flush, and the completion does not carry over to a later allocation of that slot.
- R9: A mispredicted branch is itself complete and commits normally once it is oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch offers an instruction |
| alloc_ready | output | 1 | Slot available and no flush or trap pending |
| alloc_lreg | input | LREG_W | Destination logical register |
| alloc_pnew | input | PREG_W | Newly assigned physical tag |
| alloc_pold | input | PREG_W | Physical tag previously mapped to the register |
| alloc_pc | input | PC_W | Instruction PC |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation takes |
| cmp_valid | input | 1 | Completion report |
| cmp_idx | input | log2(DEPTH) | Slot being completed |
| cmp_exc | input | 1 | Instruction raised an exception |
| cmp_mispredict | input | 1 | Branch resolved as mispredicted |
| cmt_valid | output | 1 | Commit event offered |
| cmt_ready | input | 1 | Rename logic accepts commit |
| cmt_lreg | output | LREG_W | Committed logical register |
| cmt_pnew | output | PREG_W | Tag becoming architectural |
| cmt_pold | output | PREG_W | Tag to release to the free pool |
| exc_valid | output | 1 | Trap at oldest slot |
| exc_pc | output | PC_W | PC of trapping instruction |
| exc_ack | input | 1 | Trap handled; empty the buffer |
| flush_valid | output | 1 | Younger slots squashed this cycle |
| flush_idx | output | log2(DEPTH) | Index of the mispredicted branch |

## Verification
The bench builds the block with DEPTH=4 and default widths. With that depth a handful of allocations fills the buffer and wraps the pointers, so full stall, wrap-around indexing and flush-tail rewind across the wrap point are all reached. Reuse of a squashed slot after a flush is reached as well. Out-of-order completion, a stalled commit stream, a stale completion to a squashed slot, and a trap at a non-zero head position are driven explicitly.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HEAD_EMPTY,
    HEAD_BUSY,
    HEAD_RETIRE,
    HEAD_TRAP
  } head_state_e;
endpackage

// File: rtl/rob_head_decode.sv
module rob_head_decode
  import rob_pkg::*;
(
  input  logic        head_valid,
  input  logic        head_done,
  input  logic        head_exc,
  output head_state_e state,
  output logic        retire_ok,
  output logic        trap
);
  always_comb begin
    if (!head_valid)     state = HEAD_EMPTY;
    else if (!head_done) state = HEAD_BUSY;
    else if (head_exc)   state = HEAD_TRAP;
    else                 state = HEAD_RETIRE;
  end

  assign retire_ok = (state == HEAD_RETIRE);
  assign trap      = (state == HEAD_TRAP);
endmodule

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int IDX_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_fire,
  input  logic                    retire_fire,
  input  logic                    flush_fire,
  input  logic [IDX_W-1:0]        flush_idx,
  input  logic                    clear_all,
  output logic [IDX_W-1:0]        head_idx,
  output logic [IDX_W-1:0]        tail_idx,
  output logic                    full,
  output logic [(1<<IDX_W)-1:0]   squash_mask
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] head_q, tail_q, occ, flush_tail;
  logic [IDX_W-1:0] br_off;

  assign head_idx   = head_q[IDX_W-1:0];
  assign tail_idx   = tail_q[IDX_W-1:0];
  assign occ        = tail_q - head_q;
  assign full       = occ[IDX_W];
  assign br_off     = flush_idx - head_idx;
  assign flush_tail = head_q + {1'b0, br_off} + PTR_W'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_sq
    logic [IDX_W-1:0] off;
    assign off            = IDX_W'(i) - head_idx;
    assign squash_mask[i] = flush_fire && (off > br_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (retire_fire) head_q <= head_q + PTR_W'(1);
      if (clear_all)       tail_q <= head_q;
      else if (flush_fire) tail_q <= flush_tail;
      else if (alloc_fire) tail_q <= tail_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int IDX_W  = 5,
  parameter int LREG_W = 5,
  parameter int PREG_W = 6,
  parameter int PC_W   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_fire,
  input  logic [IDX_W-1:0]      tail_idx,
  input  logic [LREG_W-1:0]     alloc_lreg,
  input  logic [PREG_W-1:0]     alloc_pnew,
  input  logic [PREG_W-1:0]     alloc_pold,
  input  logic [PC_W-1:0]       alloc_pc,
  input  logic                  cmp_valid,
  input  logic [IDX_W-1:0]      cmp_idx,
  input  logic                  cmp_exc,
  output logic                  cmp_hit,
  input  logic                  retire_fire,
  input  logic [IDX_W-1:0]      head_idx,
  input  logic [(1<<IDX_W)-1:0] squash_mask,
  input  logic                  clear_all,
  output logic                  head_valid,
  output logic                  head_done,
  output logic                  head_exc,
  output logic [LREG_W-1:0]     head_lreg,
  output logic [PREG_W-1:0]     head_pnew,
  output logic [PREG_W-1:0]     head_pold,
  output logic [PC_W-1:0]       head_pc
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_v, done_v, exc_v;
  logic [LREG_W-1:0] lreg_mem [DEPTH];
  logic [PREG_W-1:0] pnew_mem [DEPTH];
  logic [PREG_W-1:0] pold_mem [DEPTH];
  logic [PC_W-1:0]   pc_mem   [DEPTH];
  logic              cmp_fire;

  assign cmp_hit  = valid_v[cmp_idx];
  assign cmp_fire = cmp_valid && cmp_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic v_q, d_q, e_q, kill, here_alloc, here_cmp;
    assign kill       = clear_all || squash_mask[i] ||
                        (retire_fire && head_idx == IDX_W'(i));
    assign here_alloc = alloc_fire && tail_idx == IDX_W'(i);
    assign here_cmp   = cmp_fire && cmp_idx == IDX_W'(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        e_q <= 1'b0;
      end else begin
        if (kill) v_q <= 1'b0;
        else if (here_alloc) begin
          v_q <= 1'b1;
          d_q <= 1'b0;
          e_q <= 1'b0;
        end
        if (here_cmp) begin
          d_q <= 1'b1;
          e_q <= cmp_exc;
        end
      end
    end

    assign valid_v[i] = v_q;
    assign done_v[i]  = d_q;
    assign exc_v[i]   = e_q;
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      lreg_mem[tail_idx] <= alloc_lreg;
      pnew_mem[tail_idx] <= alloc_pnew;
      pold_mem[tail_idx] <= alloc_pold;
      pc_mem[tail_idx]   <= alloc_pc;
    end
  end

  assign head_valid = valid_v[head_idx];
  assign head_done  = done_v[head_idx];
  assign head_exc   = exc_v[head_idx];
  assign head_lreg  = lreg_mem[head_idx];
  assign head_pnew  = pnew_mem[head_idx];
  assign head_pold  = pold_mem[head_idx];
  assign head_pc    = pc_mem[head_idx];
endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LREG_W = 5,
  parameter int PREG_W = 6,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [LREG_W-1:0] alloc_lreg,
  input  logic [PREG_W-1:0] alloc_pnew,
  input  logic [PREG_W-1:0] alloc_pold,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic              cmp_exc,
  input  logic              cmp_mispredict,
  output logic              cmt_valid,
  input  logic              cmt_ready,
  output logic [LREG_W-1:0] cmt_lreg,
  output logic [PREG_W-1:0] cmt_pnew,
  output logic [PREG_W-1:0] cmt_pold,
  output logic              exc_valid,
  output logic [PC_W-1:0]   exc_pc,
  input  logic              exc_ack,
  output logic              flush_valid,
  output logic [IDX_W-1:0]  flush_idx
);
  logic              full, cmp_hit, alloc_fire, retire_fire, clear_all;
  logic              head_valid, head_done, head_exc;
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic [DEPTH-1:0]  squash_mask;
  head_state_e       head_state;

  assign flush_valid = cmp_valid && cmp_mispredict && cmp_hit;
  assign flush_idx   = cmp_idx;
  assign alloc_ready = !full && !flush_valid && !exc_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire_fire = cmt_valid && cmt_ready;
  assign clear_all   = exc_valid && exc_ack;
  assign alloc_idx   = tail_idx;

  rob_ptrs #(.IDX_W(IDX_W)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .retire_fire(retire_fire),
    .flush_fire (flush_valid),
    .flush_idx  (cmp_idx),
    .clear_all  (clear_all),
    .head_idx   (head_idx),
    .tail_idx   (tail_idx),
    .full       (full),
    .squash_mask(squash_mask)
  );

  rob_entries #(
    .IDX_W(IDX_W), .LREG_W(LREG_W), .PREG_W(PREG_W), .PC_W(PC_W)
  ) u_entries (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .tail_idx   (tail_idx),
    .alloc_lreg (alloc_lreg),
    .alloc_pnew (alloc_pnew),
    .alloc_pold (alloc_pold),
    .alloc_pc   (alloc_pc),
    .cmp_valid  (cmp_valid),
    .cmp_idx    (cmp_idx),
    .cmp_exc    (cmp_exc),
    .cmp_hit    (cmp_hit),
    .retire_fire(retire_fire),
    .head_idx   (head_idx),
    .squash_mask(squash_mask),
    .clear_all  (clear_all),
    .head_valid (head_valid),
    .head_done  (head_done),
    .head_exc   (head_exc),
    .head_lreg  (cmt_lreg),
    .head_pnew  (cmt_pnew),
    .head_pold  (cmt_pold),
    .head_pc    (exc_pc)
  );

  rob_head_decode u_decode (
    .head_valid(head_valid),
    .head_done (head_done),
    .head_exc  (head_exc),
    .state     (head_state),
    .retire_ok (cmt_valid),
    .trap      (exc_valid)
  );
endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk #(
  parameter int IDX_W  = 5,
  parameter int LREG_W = 5,
  parameter int PREG_W = 6,
  parameter int PC_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic [IDX_W-1:0]  alloc_idx,
  input logic              cmt_valid,
  input logic              cmt_ready,
  input logic [LREG_W-1:0] cmt_lreg,
  input logic [PREG_W-1:0] cmt_pnew,
  input logic [PREG_W-1:0] cmt_pold,
  input logic              exc_valid,
  input logic [PC_W-1:0]   exc_pc,
  input logic              exc_ack,
  input logic              flush_valid,
  input logic [IDX_W-1:0]  flush_idx
);
  a_r1_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_idx == IDX_W'($past(alloc_idx) + 1'b1));

  a_r3_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !cmt_ready) |=> cmt_valid && $stable(cmt_lreg) &&
                                  $stable(cmt_pnew) && $stable(cmt_pold));

  a_r5_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !exc_ack) |=> exc_valid && $stable(exc_pc) && !cmt_valid);

  a_r6_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_ack) |=> !exc_valid && !cmt_valid && alloc_ready);

  a_r7_flush_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> alloc_idx == IDX_W'($past(flush_idx) + 1'b1));
endmodule

bind rob_commit_ctrl rob_commit_chk #(
  .IDX_W(IDX_W), .LREG_W(LREG_W), .PREG_W(PREG_W), .PC_W(PC_W)
) u_chk (.*);

// File: tb/rob_commit_ctrl_bench.sv
module rob_commit_ctrl_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 4;
  localparam int IW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_ready;
  logic [4:0] alloc_lreg = 0;
  logic [5:0] alloc_pnew = 0, alloc_pold = 0;
  logic [31:0] alloc_pc = 0;
  logic [IW-1:0] alloc_idx;
  logic cmp_valid = 0, cmp_exc = 0, cmp_mispredict = 0;
  logic [IW-1:0] cmp_idx = 0;
  logic cmt_valid, cmt_ready = 0;
  logic [4:0] cmt_lreg;
  logic [5:0] cmt_pnew, cmt_pold;
  logic exc_valid, exc_ack = 0, flush_valid;
  logic [31:0] exc_pc;
  logic [IW-1:0] flush_idx;

  always #2.5 clk = ~clk;

  rob_commit_ctrl #(.DEPTH(DEPTH)) u_rob_commit_ctrl (.*);

  typedef struct { int idx; int lreg; int pnew; int pold; } exp_t;
  exp_t q[$];
  exp_t e;
  int checks = 0, errors = 0, commits = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmt_valid && cmt_ready) begin
      if (q.size() == 0) chk("R4 unexpected commit", 1, 0);
      else begin
        e = q.pop_front();
        chk("R4 commit lreg", int'(cmt_lreg), e.lreg);
        chk("R4 commit pnew", int'(cmt_pnew), e.pnew);
        chk("R4 commit pold", int'(cmt_pold), e.pold);
        commits++;
      end
    end
  end

  task automatic do_alloc(input int lr, input int pn, input int po, input int pc,
                          input int exp_idx);
    exp_t it;
    alloc_valid = 1; alloc_lreg = 5'(lr); alloc_pnew = 6'(pn);
    alloc_pold = 6'(po); alloc_pc = 32'(pc);
    @(negedge clk);
    while (!alloc_ready) @(negedge clk);
    chk("R1 alloc index", int'(alloc_idx), exp_idx);
    it.idx = int'(alloc_idx); it.lreg = lr; it.pnew = pn; it.pold = po;
    q.push_back(it);
    @(posedge clk); #1 alloc_valid = 0;
  endtask

  task automatic complete(input int idx, input bit ex, input bit mis,
                          input bit exp_fl, input string req);
    cmp_valid = 1; cmp_idx = IW'(idx); cmp_exc = ex; cmp_mispredict = mis;
    @(negedge clk);
    chk(req, int'(flush_valid), int'(exp_fl));
    if (exp_fl) begin
      chk("R7 flush_idx", int'(flush_idx), idx);
      chk("R7 alloc_ready low in flush", int'(alloc_ready), 0);
    end
    @(posedge clk); #1 cmp_valid = 0; cmp_exc = 0; cmp_mispredict = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset alloc_ready", int'(alloc_ready), 1);
    chk("R1 reset alloc_idx", int'(alloc_idx), 0);
    chk("R3 reset cmt_valid", int'(cmt_valid), 0);
    chk("R5 reset exc_valid", int'(exc_valid), 0);
    chk("R7 reset flush_valid", int'(flush_valid), 0);
    @(posedge clk); #1;

    // fill, out-of-order completion, stalled commit
    for (int i = 0; i < 4; i++) do_alloc(i + 1, 32 + i, i + 10, 'h100 + 4 * i, i);
    @(negedge clk);
    chk("R2 full blocks alloc", int'(alloc_ready), 0);
    @(posedge clk); #1;
    complete(2, 0, 0, 0, "R8 no flush plain cmp");
    complete(1, 0, 0, 0, "R8 no flush plain cmp");
    complete(3, 0, 0, 0, "R8 no flush plain cmp");
    @(negedge clk);
    chk("R3 younger done, head busy", int'(cmt_valid), 0);
    @(posedge clk); #1;
    complete(0, 0, 0, 0, "R8 no flush plain cmp");
    @(negedge clk);
    chk("R3 head offered", int'(cmt_valid), 1);
    chk("R3 head lreg", int'(cmt_lreg), 1);
    @(negedge clk);
    chk("R3 held under backpressure", int'(cmt_valid), 1);
    chk("R3 payload held", int'(cmt_pnew), 32);
    @(posedge clk); #1 cmt_ready = 1;
    cycles(6);
    chk("R4 four commits", commits, 4);
    chk("R3 empty after drain", int'(cmt_valid), 0);

    // wrap and mispredict flush
    do_alloc(6, 40, 1, 'h200, 0);
    do_alloc(7, 41, 2, 'h204, 1);
    do_alloc(8, 42, 3, 'h208, 2);
    do_alloc(9, 43, 4, 'h20c, 3);
    complete(1, 0, 1, 1, "R7 flush same cycle");
    while (q.size() > 0 && q[$].idx != 1) q.delete(q.size() - 1);
    @(negedge clk);
    chk("R7 tail rewound", int'(alloc_idx), 2);
    @(posedge clk); #1;
    complete(2, 0, 1, 0, "R8 stale cmp no flush");
    do_alloc(10, 44, 5, 'h300, 2);
    complete(0, 0, 0, 0, "R8 no flush plain cmp");
    cycles(5);
    chk("R9 branch committed", commits, 6);
    chk("R8 stale cmp not carried", int'(cmt_valid), 0);
    complete(2, 0, 0, 0, "R8 no flush plain cmp");
    cycles(3);
    chk("R4 reused slot commits", commits, 7);

    // exception at head
    do_alloc(11, 45, 6, 'h400, 3);
    do_alloc(12, 46, 7, 'h404, 0);
    complete(0, 0, 0, 0, "R8 no flush plain cmp");
    complete(3, 1, 0, 0, "R8 no flush exc cmp");
    @(negedge clk);
    chk("R5 exc_valid", int'(exc_valid), 1);
    chk("R5 exc_pc", int'(exc_pc), 'h400);
    chk("R5 no commit", int'(cmt_valid), 0);
    chk("R5 alloc blocked", int'(alloc_ready), 0);
    cycles(2);
    @(negedge clk);
    chk("R5 trap held", int'(exc_valid), 1);
    q.delete();
    @(posedge clk); #1 exc_ack = 1;
    @(posedge clk); #1 exc_ack = 0;
    @(negedge clk);
    chk("R6 exc cleared", int'(exc_valid), 0);
    chk("R6 empty", int'(cmt_valid), 0);
    chk("R6 alloc_ready", int'(alloc_ready), 1);
    chk("R6 alloc_idx at trapped slot", int'(alloc_idx), 3);
    @(posedge clk); #1;
    do_alloc(13, 47, 8, 'h500, 3);
    complete(3, 0, 0, 0, "R8 no flush plain cmp");
    cycles(3);
    chk("R4 total commits", commits, 8);
    chk("R4 scoreboard drained", q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule